// File: doc/BRIEF.md
# Processor bus-cycle controller with memory routing

This block connects an early x86 processor with an 8-bit multiplexed address/data bus to the on-chip fabric. It runs on a fast system clock and watches the processor's strobes by edge detection. On the falling edge of the address-latch strobe it latches the 20-bit address and the memory/IO status. On the falling edge of a read or write strobe it classifies the bus cycle as memory read, memory write, IO read or IO write. It then serves read data while the read strobe is low, or commits write data once the write strobe is released. Because it never counts processor clocks to time a cycle, the processor clock may run at any rate, including a full stop.

Each access is routed by address. Reads in the top 64 KB come from a boot-ROM block RAM. Ordinary memory below 640 KB lives in an external SRAM. Writes to the 16 KB video window go to both the SRAM and the write port of a dual-port video RAM. Reads of the video window are served by the SRAM, so the video RAM's other port stays free for a display scanner. IO cycles reach an LED register used for bring-up, or a generic peripheral port. A parameter inserts wait states on SRAM-backed accesses.

Top module: `cpu_bus_ctrl`

## Requirements
- R1: The address is {a_hi_i, ad_i} and the status bit iom_i (1 = IO, 0 = memory) is taken in the clock where ale_i is first seen low after being high. Both are held until the next such clock, whatever the address lines do meanwhile.
- R2: A memory read at F0000h or above returns rom_rdata_i, with rom_addr_o equal to the low 16 address bits. The ROM has one clock of read latency. sram_oe_no stays high during such a read.
- R3: A memory read below A0000h, or inside the video window B8000h–BBFFFh, returns sram_rdata_i for the latched address, with sram_oe_no low while the read strobe is low.
- R4: A memory write below A0000h gives one clock of sram_we_no low after the write strobe is released, carrying the last byte seen on ad_i while the strobe was low. vram_we_o stays low.
- R5: A memory write inside the video window pulses sram_we_no low and vram_we_o high in the same single clock. vram_addr_o is the address modulo 16 KB.
- R6: Memory addresses from A0000h to EFFFFh outside the video window are unmapped. Reads return FFh and writes cause no SRAM or video RAM write.
- R7: An IO write to port 00E0h loads led_o. An IO read of port 00E0h returns the LED value.
- R8: An IO access to any other port gives one clock of io_wr_o with io_addr_o/io_wdata_o on write, or returns io_rdata_i with io_rd_o high on read. An IO access never touches the SRAM.
- R9: ad_oe_o is low at reset and outside read cycles, and high during a read while rd_ni is low.
- R10: With WAIT_STATES = N > 0, ready_o drops in the clock after a read or write strobe falls on an SRAM-backed memory address. It rises again after N rising edges of cpu_clk_i. For ROM, unmapped and IO accesses ready_o stays high.
- R11: A write commits to the address of its own cycle, even when the next cycle's address is latched on the same clock edge.
- R12: sram_oe_no and sram_we_no are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_clk_i | input | 1 | Processor clock, used only to count wait states |
| ale_i | input | 1 | Address-latch strobe |
| iom_i | input | 1 | Status: 1 = IO cycle, 0 = memory cycle |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| a_hi_i | input | 12 | Address bits 19:8 |
| ad_i | input | 8 | Multiplexed address bits 7:0 / write data |
| ad_o | output | 8 | Read data to the processor |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ready_o | output | 1 | Ready to the processor |
| rom_addr_o | output | 16 | Boot-ROM address |
| rom_rdata_i | input | 8 | Boot-ROM data, one clock after the address |
| sram_addr_o | output | 20 | External SRAM address |
| sram_wdata_o | output | 8 | External SRAM write data |
| sram_rdata_i | input | 8 | External SRAM read data |
| sram_oe_no | output | 1 | SRAM output enable, active low |
| sram_we_no | output | 1 | SRAM write enable, active low |
| vram_addr_o | output | 14 | Video RAM write address |
| vram_wdata_o | output | 8 | Video RAM write data |
| vram_we_o | output | 1 | Video RAM write enable |
| io_addr_o | output | 16 | Peripheral port address |
| io_wdata_o | output | 8 | Peripheral write data |
| io_rdata_i | input | 8 | Peripheral read data |
| io_rd_o | output | 1 | Peripheral read select |
| io_wr_o | output | 1 | Peripheral write pulse |
| led_o | output | 8 | Bring-up LED register |

## Verification
Two things can fall on one clock edge: the commit of a finished write and the latching of the next cycle's address. This happens when the address strobe of the next cycle is raised while the write strobe is still low, and is dropped in the same clock in which the write strobe is released. The bench builds exactly that sequence, follows it with a read, and records every SRAM write pulse. The test passes only if the recorded write carries the old address and old data, while the following read still uses the new address.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE, CYC_MEM_RD, CYC_MEM_WR, CYC_IO_RD, CYC_IO_WR
  } cyc_e;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_ROM, TGT_RAM, TGT_VID, TGT_LED, TGT_IO
  } tgt_e;

  // targets backed by the external SRAM
  function automatic logic is_slow(tgt_e t);
    return (t == TGT_RAM) || (t == TGT_VID);
  endfunction
endpackage

// File: rtl/cpu_bus_latch.sv
module cpu_bus_latch #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ale_i,
  input  logic          iom_i,
  input  logic [AW-1:DW] a_hi_i,
  input  logic [DW-1:0] ad_i,
  output logic [AW-1:0] addr_o,
  output logic          io_o
);
  logic          ale_q;
  logic [AW-1:0] addr_q;
  logic          io_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q  <= 1'b0;
      addr_q <= '0;
      io_q   <= 1'b0;
    end else begin
      ale_q <= ale_i;
      if (ale_q && !ale_i) begin
        addr_q <= {a_hi_i, ad_i};
        io_q   <= iom_i;
      end
    end
  end

  assign addr_o = addr_q;
  assign io_o   = io_q;
endmodule

// File: rtl/cpu_bus_decode.sv
module cpu_bus_decode
  import cpu_bus_pkg::*;
#(
  parameter int          AW       = 20,
  parameter int          IO_AW    = 16,
  parameter int          VID_AW   = 14,
  parameter logic [AW-1:0] ROM_BASE = 20'hF0000,
  parameter logic [AW-1:0] VID_BASE = 20'hB8000,
  parameter logic [AW-1:0] RAM_TOP  = 20'hA0000,
  parameter logic [IO_AW-1:0] LED_PORT = 16'h00E0
) (
  input  logic [AW-1:0] addr_i,
  input  logic          io_i,
  output tgt_e          tgt_o
);
  logic vid_hit;
  assign vid_hit = addr_i[AW-1:VID_AW] == VID_BASE[AW-1:VID_AW];

  always_comb begin
    if (io_i)
      tgt_o = (addr_i[IO_AW-1:0] == LED_PORT) ? TGT_LED : TGT_IO;
    else if (addr_i >= ROM_BASE)
      tgt_o = TGT_ROM;
    else if (vid_hit)
      tgt_o = TGT_VID;
    else if (addr_i < RAM_TOP)
      tgt_o = TGT_RAM;
    else
      tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/cpu_bus_wait.sv
module cpu_bus_wait #(
  parameter int WAIT_STATES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cpu_clk_i,
  output logic ready_o
);
  if (WAIT_STATES == 0) begin : g_nowait
    logic unused_w;
    assign unused_w = ^{clk_i, rst_ni, start_i, cpu_clk_i};
    assign ready_o  = 1'b1;
  end else begin : g_wait
    localparam int CW = $clog2(WAIT_STATES + 1);
    logic          cpu_q, busy_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cpu_q  <= 1'b0;
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cpu_q <= cpu_clk_i;
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end else if (busy_q && cpu_clk_i && !cpu_q) begin
          if (cnt_q == CW'(WAIT_STATES - 1)) busy_q <= 1'b0;
          else                               cnt_q  <= cnt_q + 1'b1;
        end
      end
    end

    assign ready_o = !busy_q;
  end
endmodule

// File: rtl/cpu_bus_ctrl.sv
module cpu_bus_ctrl
  import cpu_bus_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 8,
  parameter int IO_AW       = 16,
  parameter int ROM_AW      = 16,
  parameter int VID_AW      = 14,
  parameter logic [AW-1:0] ROM_BASE = 20'hF0000,
  parameter logic [AW-1:0] VID_BASE = 20'hB8000,
  parameter logic [AW-1:0] RAM_TOP  = 20'hA0000,
  parameter logic [IO_AW-1:0] LED_PORT = 16'h00E0,
  parameter int WAIT_STATES = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_clk_i,
  input  logic              ale_i,
  input  logic              iom_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [AW-1:DW]    a_hi_i,
  input  logic [DW-1:0]     ad_i,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe_o,
  output logic              ready_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [DW-1:0]     rom_rdata_i,
  output logic [AW-1:0]     sram_addr_o,
  output logic [DW-1:0]     sram_wdata_o,
  input  logic [DW-1:0]     sram_rdata_i,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [VID_AW-1:0] vram_addr_o,
  output logic [DW-1:0]     vram_wdata_o,
  output logic              vram_we_o,
  output logic [IO_AW-1:0]  io_addr_o,
  output logic [DW-1:0]     io_wdata_o,
  input  logic [DW-1:0]     io_rdata_i,
  output logic              io_rd_o,
  output logic              io_wr_o,
  output logic [DW-1:0]     led_o
);
  logic [AW-1:0] addr;
  logic          is_io;
  tgt_e          tgt;

  cpu_bus_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk_i, .rst_ni, .ale_i, .iom_i, .a_hi_i, .ad_i,
    .addr_o(addr), .io_o(is_io)
  );

  cpu_bus_decode #(
    .AW(AW), .IO_AW(IO_AW), .VID_AW(VID_AW), .ROM_BASE(ROM_BASE),
    .VID_BASE(VID_BASE), .RAM_TOP(RAM_TOP), .LED_PORT(LED_PORT)
  ) u_dec (
    .addr_i(addr), .io_i(is_io), .tgt_o(tgt)
  );

  logic rd_q, wr_q;
  logic rd_fall, wr_fall, wr_rise;
  cyc_e cyc_q;
  logic rd_act, wr_act, wr_cyc;

  assign rd_fall = rd_q && !rd_ni;
  assign wr_fall = wr_q && !wr_ni;
  assign wr_rise = !wr_q && wr_ni;
  assign wr_cyc  = (cyc_q == CYC_MEM_WR) || (cyc_q == CYC_IO_WR);
  assign rd_act  = ((cyc_q == CYC_MEM_RD) || (cyc_q == CYC_IO_RD)) && !rd_ni;
  assign wr_act  = wr_cyc && !wr_ni;

  logic [DW-1:0] rd_mux, rdata_q, wdata_q, led_q;
  logic          wr_stb_q;
  tgt_e          wr_tgt_q;
  logic [AW-1:0] wr_addr_q;

  always_comb begin
    unique case (tgt)
      TGT_ROM:          rd_mux = rom_rdata_i;
      TGT_RAM, TGT_VID: rd_mux = sram_rdata_i;
      TGT_LED:          rd_mux = led_q;
      TGT_IO:           rd_mux = io_rdata_i;
      default:          rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b1;
      wr_q      <= 1'b1;
      cyc_q     <= CYC_IDLE;
      rdata_q   <= '0;
      wdata_q   <= '0;
      wr_stb_q  <= 1'b0;
      wr_tgt_q  <= TGT_NONE;
      wr_addr_q <= '0;
      led_q     <= '0;
    end else begin
      rd_q <= rd_ni;
      wr_q <= wr_ni;
      if (rd_fall)             cyc_q <= is_io ? CYC_IO_RD : CYC_MEM_RD;
      else if (wr_fall)        cyc_q <= is_io ? CYC_IO_WR : CYC_MEM_WR;
      else if (rd_ni && wr_ni) cyc_q <= CYC_IDLE;
      if (rd_act) rdata_q <= rd_mux;
      // data phase only: the bus carries an address while ale_i is high
      if (wr_act && !ale_i) wdata_q <= ad_i;
      // the commit keeps its own address so a new latch cannot redirect it
      wr_stb_q <= wr_rise && wr_cyc;
      if (wr_rise && wr_cyc) begin
        wr_tgt_q  <= tgt;
        wr_addr_q <= addr;
      end
      if (wr_stb_q && wr_tgt_q == TGT_LED) led_q <= wdata_q;
    end
  end

  cpu_bus_wait #(.WAIT_STATES(WAIT_STATES)) u_wait (
    .clk_i, .rst_ni,
    .start_i((rd_fall || wr_fall) && !is_io && is_slow(tgt)),
    .cpu_clk_i, .ready_o
  );

  assign ad_o         = rdata_q;
  assign ad_oe_o      = rd_act;
  assign rom_addr_o   = addr[ROM_AW-1:0];
  assign sram_addr_o  = wr_stb_q ? wr_addr_q : addr;
  assign sram_wdata_o = wdata_q;
  assign sram_oe_no   = !(rd_act && cyc_q == CYC_MEM_RD && is_slow(tgt));
  assign sram_we_no   = !(wr_stb_q && is_slow(wr_tgt_q));
  assign vram_addr_o  = wr_addr_q[VID_AW-1:0];
  assign vram_wdata_o = wdata_q;
  assign vram_we_o    = wr_stb_q && wr_tgt_q == TGT_VID;
  assign io_addr_o    = wr_stb_q ? wr_addr_q[IO_AW-1:0] : addr[IO_AW-1:0];
  assign io_wdata_o   = wdata_q;
  assign io_rd_o      = rd_act && tgt == TGT_IO;
  assign io_wr_o      = wr_stb_q && wr_tgt_q == TGT_IO;
  assign led_o        = led_q;
endmodule

// File: rtl/cpu_bus_ctrl_chk.sv
module cpu_bus_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_ni,
  input logic          wr_ni,
  input logic          ready_o,
  input logic          sram_oe_no,
  input logic          sram_we_no,
  input logic          vram_we_o,
  input logic          io_wr_o,
  input logic [DW-1:0] led_o,
  input logic          wr_stb_q
);
  a_r12_no_oe_we_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_no && !sram_we_no));

  a_r4_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |=> sram_we_no);

  a_r5_vram_mirrored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_we_o |-> !sram_we_no);

  a_r8_io_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_o |=> !io_wr_o);

  a_r7_led_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(led_o) |-> $past(wr_stb_q));

  a_r10_wait_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (!rd_ni || !wr_ni));
endmodule

bind cpu_bus_ctrl cpu_bus_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
  .ready_o(ready_o), .sram_oe_no(sram_oe_no), .sram_we_no(sram_we_no),
  .vram_we_o(vram_we_o), .io_wr_o(io_wr_o), .led_o(led_o),
  .wr_stb_q(wr_stb_q)
);

// File: tb/test_cpu_bus_ctrl.sv
`timescale 1ns/1ps
module test_cpu_bus_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cpu_clk = 1'b0, ale = 1'b0, iom = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [19:8] a_hi = '0;
  logic [7:0]  ad = '0;
  logic [7:0]  ad_o, rom_rdata, sram_rdata, sram_wdata, vram_wdata, io_wdata, io_rdata, led;
  logic        ad_oe, ready, sram_oe_n, sram_we_n, vram_we, io_rd, io_wr;
  logic [15:0] rom_addr, io_addr;
  logic [19:0] sram_addr;
  logic [13:0] vram_addr;

  always #2.5 clk = ~clk;

  cpu_bus_ctrl #(.WAIT_STATES(2)) i_cpu_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_clk_i(cpu_clk), .ale_i(ale), .iom_i(iom),
    .rd_ni(rd_n), .wr_ni(wr_n), .a_hi_i(a_hi), .ad_i(ad), .ad_o(ad_o),
    .ad_oe_o(ad_oe), .ready_o(ready), .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata),
    .sram_addr_o(sram_addr), .sram_wdata_o(sram_wdata), .sram_rdata_i(sram_rdata),
    .sram_oe_no(sram_oe_n), .sram_we_no(sram_we_n), .vram_addr_o(vram_addr),
    .vram_wdata_o(vram_wdata), .vram_we_o(vram_we), .io_addr_o(io_addr),
    .io_wdata_o(io_wdata), .io_rdata_i(io_rdata), .io_rd_o(io_rd), .io_wr_o(io_wr),
    .led_o(led)
  );

  function automatic logic [7:0] sram_pat(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]};
  endfunction
  function automatic logic [7:0] rom_pat(logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // memory models
  always @(posedge clk) rom_rdata <= rom_pat(rom_addr);
  assign sram_rdata = sram_pat(sram_addr);
  assign io_rdata   = io_addr[7:0] + 8'h11;

  int checks = 0, failures = 0;
  int n_we, n_vwe, n_both, n_oe, n_clash, n_iow, n_ior;
  logic [19:0] we_addr;
  logic [7:0]  we_data, v_data, iow_data;
  logic [13:0] v_addr;
  logic [15:0] iow_addr;

  always @(negedge clk) if (rst_ni) begin
    if (!sram_we_n) begin
      n_we++; we_addr = sram_addr; we_data = sram_wdata;
      if (vram_we) n_both++;
    end
    if (vram_we) begin n_vwe++; v_addr = vram_addr; v_data = vram_wdata; end
    if (!sram_oe_n) n_oe++;
    if (!sram_oe_n && !sram_we_n) n_clash++;
    if (io_wr) begin n_iow++; iow_addr = io_addr; iow_data = io_wdata; end
    if (io_rd) n_ior++;
  end

  task automatic clr_mon();
    n_we = 0; n_vwe = 0; n_both = 0; n_oe = 0; n_iow = 0; n_ior = 0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_ready(output int waits);
    waits = 0;
    while (!ready && waits < 8) begin
      cpu_clk = 1'b1; repeat (2) @(negedge clk);
      cpu_clk = 1'b0; repeat (2) @(negedge clk);
      waits++;
    end
  endtask

  task automatic addr_phase(logic io, logic [19:0] a);
    @(negedge clk); ale = 1'b1; iom = io; a_hi = a[19:8]; ad = a[7:0];
    @(negedge clk); ale = 1'b0;
  endtask

  task automatic bus_read(logic io, logic [19:0] a, output logic [7:0] d, output int waits);
    addr_phase(io, a);
    @(negedge clk); rd_n = 1'b0; ad = 8'h00; a_hi = ~a[19:8];
    repeat (2) @(negedge clk);
    wait_ready(waits);
    repeat (2) @(negedge clk);
    d = ad_o;
    check("R9 oe during read", ad_oe, 1);
    @(negedge clk); rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 oe after read", ad_oe, 0);
  endtask

  task automatic bus_write(logic io, logic [19:0] a, logic [7:0] d, output int waits);
    addr_phase(io, a);
    @(negedge clk); wr_n = 1'b0; ad = d; a_hi = ~a[19:8];
    repeat (2) @(negedge clk);
    wait_ready(waits);
    @(negedge clk); wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 reset ad_oe", ad_oe, 0);
    check("R10 reset ready", ready, 1);
    check("R12 reset sram strobes", {sram_oe_n, sram_we_n}, 2'b11);
    check("R5 reset vram_we", vram_we, 0);
    check("R7 reset led", led, 0);
  endtask

  task automatic t_rom_read();
    logic [7:0] d; int w;
    clr_mon();
    bus_read(1'b0, 20'hF1234, d, w);
    check("R2 rom data", d, rom_pat(16'h1234));
    check("R2 sram untouched", n_oe, 0);
    check("R10 rom no wait", w, 0);
  endtask

  task automatic t_ram_read();
    logic [7:0] d; int w;
    clr_mon();
    bus_read(1'b0, 20'h12345, d, w);
    check("R3 ram data", d, sram_pat(20'h12345));
    check("R3 sram oe seen", n_oe > 0, 1);
    check("R10 ram waits", w, 2);
    clr_mon();
    bus_read(1'b0, 20'hB8010, d, w);
    check("R3 video read from sram", d, sram_pat(20'hB8010));
    check("R3 video read no vram write", n_vwe, 0);
    // R1: high lines scrambled during data phase
    bus_read(1'b0, 20'h00777, d, w);
    check("R1 latched address held", d, sram_pat(20'h00777));
  endtask

  task automatic t_ram_write();
    int w;
    clr_mon();
    bus_write(1'b0, 20'h01234, 8'hA5, w);
    check("R4 one we pulse", n_we, 1);
    check("R4 we addr", we_addr, 20'h01234);
    check("R4 we data", we_data, 8'hA5);
    check("R4 no vram", n_vwe, 0);
    check("R10 write waits", w, 2);
  endtask

  task automatic t_vid_write();
    int w;
    clr_mon();
    bus_write(1'b0, 20'hB8123, 8'h3C, w);
    check("R5 sram we", n_we, 1);
    check("R5 vram we", n_vwe, 1);
    check("R5 same clock", n_both, 1);
    check("R5 sram addr", we_addr, 20'hB8123);
    check("R5 vram addr", v_addr, 14'h0123);
    check("R5 vram data", v_data, 8'h3C);
  endtask

  task automatic t_unmapped();
    logic [7:0] d; int w;
    clr_mon();
    bus_read(1'b0, 20'hC0000, d, w);
    check("R6 unmapped read", d, 8'hFF);
    check("R6 unmapped no wait", w, 0);
    bus_write(1'b0, 20'hA5000, 8'h42, w);
    check("R6 unmapped no writes", n_we + n_vwe + n_oe, 0);
  endtask

  task automatic t_led();
    logic [7:0] d; int w;
    clr_mon();
    bus_write(1'b1, 20'h000E0, 8'h5A, w);
    check("R7 led value", led, 8'h5A);
    bus_read(1'b1, 20'h000E0, d, w);
    check("R7 led readback", d, 8'h5A);
    check("R7 no periph or sram", n_iow + n_we + n_oe, 0);
  endtask

  task automatic t_io();
    logic [7:0] d; int w;
    clr_mon();
    bus_write(1'b1, 20'h00061, 8'h77, w);
    check("R8 io_wr pulse", n_iow, 1);
    check("R8 io addr", iow_addr, 16'h0061);
    check("R8 io data", iow_data, 8'h77);
    check("R10 io no wait", w, 0);
    bus_read(1'b1, 20'h00042, d, w);
    check("R8 io read data", d, 8'h53);
    check("R8 io_rd seen", n_ior > 0, 1);
    check("R8 no sram", n_we + n_oe, 0);
    check("R7 led unchanged", led, 8'h5A);
  endtask

  task automatic t_overlap();
    logic [7:0] d; int w;
    clr_mon();
    addr_phase(1'b0, 20'h00400);
    @(negedge clk); wr_n = 1'b0; ad = 8'h99; a_hi = 12'hFFF;
    repeat (2) @(negedge clk);
    wait_ready(w);
    // next address phase starts while write strobe still low
    @(negedge clk); ale = 1'b1; a_hi = 12'h005; ad = 8'h00;
    @(negedge clk); ale = 1'b0; wr_n = 1'b1;
    @(negedge clk); rd_n = 1'b0; a_hi = 12'hFFA;
    repeat (2) @(negedge clk);
    wait_ready(w);
    repeat (2) @(negedge clk);
    d = ad_o;
    @(negedge clk); rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 one write", n_we, 1);
    check("R11 write addr", we_addr, 20'h00400);
    check("R11 write data", we_data, 8'h99);
    check("R11 next read addr", d, sram_pat(20'h00500));
  endtask

  initial begin
    n_clash = 0;
    clr_mon();
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rom_read();
    t_ram_read();
    t_ram_write();
    t_vid_write();
    t_unmapped();
    t_led();
    t_io();
    t_overlap();
    check("R12 no oe/we clash", n_clash, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule